// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block gathers 32 level-sensitive interrupt sources and sends them, as processor interrupt levels, to one chosen CPU out of up to sixteen. Each source input is captured into a pending bit that tracks the input level. A fixed, irregular map assigns each source bit a level from 1 to 15, or no level at all. Several sources may share a level.

A disable register masks pending bits from the outputs without clearing them. Its top bit is a master switch that cuts off every hard interrupt at once. A target register selects the single CPU that receives the level vector. Every other CPU sees an all-zero vector. Each CPU's 16-bit output is a one-hot-per-level set, which a per-CPU combiner downstream merges with its local sources.

Software reaches the registers through a simple 32-bit word interface. Reads are combinational from the word offset. Writes take effect at the next clock edge. Outputs are recomputed from register state with no added pipeline stage.

Top module: `sysirq_router`

## Requirements
- R1: After reset the pending register reads 0, the disable register reads 0 (offset 1), the target reads 0 (offset 4), and every CPU level vector is 0.
- R2: A pending bit is set while its source input is high and clear while it is low, one clock edge after the input. Sources 23 to 26 and 31 have no level: their pending bits stay 0 and they never drive an output. Reading offset 0 returns the pending bits with bit 31 forced to 0.
- R3: Reads from word offsets 5, 6 and 7 return 0.
- R4: A write to offset 2 clears, in the disable register, the written bits that lie inside the writable mask 0xF05DFF80.
- R5: A write to offset 3 sets, in the disable register, the written bits that lie inside the writable mask. It leaves the pending bits unchanged. A disabled source stops driving its level while it stays pending.
- R6: A write to offset 4 stores the low 4 bits of the data as the target CPU. Offset 4 reads them back, zero-extended.
- R7: While disable bit 31 (the master switch) is set, every CPU level vector is 0, whatever is pending.
- R8: The level map is fixed. Sources 0–6 and, separately, 7–13 map in order to levels 2, 3, 5, 7, 9, 11, 13. Sources 14 and 15 map to 12. Sources 16–22 map to 6, 13, 4, 10, 8, 9, 11. Sources 27–30 map to 15. Level bit L of a vector is set when some enabled, pending source maps to L.
- R9: Only the CPU whose number equals the target register receives the level vector. It appears on bits [16*c+15:16*c] of the output. All other CPUs receive 0.
- R10: Disable bits outside the writable mask (reset pattern 0x0FA2007F) stay set forever. Sources 0–6, 17, 21 and 27 therefore never reach an output.
- R11: Writes to offsets 0, 1, 5, 6 and 7 change no register.
- R12: A source change or register write shows on the level outputs after exactly one clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive source inputs |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| cpu_lvl_o | output | 256 | Sixteen 16-bit level vectors, CPU c at [16c+15:16c] |

## Verification
A source edge and a disable-register write can land on the same clock edge. Both update state that feeds the same level encoder. The bench provokes this in two ways. In the first, it raises a source while, in the same cycle, it writes offset 3 to disable that source. In the second, it writes offset 2 to re-enable one source while, in the same cycle, it raises another. After the edge it reads back pending and disable at the ports. The level vector must show the pending bit set but masked in the first case, and both levels present in the second.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
  localparam int unsigned NUM_SRC  = 32;
  localparam int unsigned NUM_LVL  = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned LVL_IDX_W = $clog2(NUM_LVL);

  localparam logic [DATA_W-1:0] WR_MASK   = 32'hF05D_FF80;
  localparam logic [DATA_W-1:0] DIS_RST   = ~WR_MASK;
  localparam int unsigned       MASTER_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    OFS_PEND = 3'd0,
    OFS_DIS  = 3'd1,
    OFS_EN   = 3'd2,
    OFS_DSET = 3'd3,
    OFS_TGT  = 3'd4
  } reg_ofs_e;

  // Level for a source bit; 0 means unrouted
  function automatic logic [LVL_IDX_W-1:0] lvl_of(input int unsigned b);
    case (b)
      0, 7:           lvl_of = 4'd2;
      1, 8:           lvl_of = 4'd3;
      2, 9:           lvl_of = 4'd5;
      3, 10:          lvl_of = 4'd7;
      4, 11:          lvl_of = 4'd9;
      5, 12:          lvl_of = 4'd11;
      6, 13:          lvl_of = 4'd13;
      14, 15:         lvl_of = 4'd12;
      16:             lvl_of = 4'd6;
      17:             lvl_of = 4'd13;
      18:             lvl_of = 4'd4;
      19:             lvl_of = 4'd10;
      20:             lvl_of = 4'd8;
      21:             lvl_of = 4'd9;
      22:             lvl_of = 4'd11;
      27, 28, 29, 30: lvl_of = 4'd15;
      default:        lvl_of = 4'd0;
    endcase
  endfunction

  function automatic logic [NUM_SRC-1:0] routed_mask();
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < NUM_SRC; b++) m[b] = (lvl_of(b) != '0);
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] ROUTED = routed_mask();
endpackage

// File: rtl/sysirq_src_latch.sv
module sysirq_src_latch
  import sysirq_pkg::*;
#(
  parameter int unsigned SRC_W = NUM_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] pend_o
);
  logic [SRC_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= src_i & ROUTED[SRC_W-1:0];
  end

  assign pend_o = pend_q;

  // R2
  pend_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ROUTED[SRC_W-1:0]) == ($past(src_i) & ROUTED[SRC_W-1:0])));

  // R2
  unrouted_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~ROUTED[SRC_W-1:0]) == '0);
endmodule

// File: rtl/sysirq_ctl_regs.sv
module sysirq_ctl_regs
  import sysirq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 16,
  localparam int unsigned TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] dis_o,
  output logic [TGT_W-1:0]  tgt_o
);
  logic [DATA_W-1:0] dis_q, dis_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic              wr;
  logic [DATA_W-1:0] wbits;

  assign wr    = req_i & we_i;
  assign wbits = wdata_i & WR_MASK;

  always_comb begin
    dis_d = dis_q;
    tgt_d = tgt_q;
    if (wr) begin
      case (addr_i)
        OFS_EN:   dis_d = dis_q & ~wbits;
        OFS_DSET: dis_d = dis_q | wbits;
        OFS_TGT:  tgt_d = wdata_i[TGT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= DIS_RST;
      tgt_q <= '0;
    end else begin
      dis_q <= dis_d;
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_PEND: rdata_o = pend_i & ~(DATA_W'(1) << MASTER_BIT);
      OFS_DIS:  rdata_o = dis_q & WR_MASK;
      OFS_TGT:  rdata_o = DATA_W'(tgt_q);
      default:  rdata_o = '0;
    endcase
  end

  assign dis_o = dis_q;
  assign tgt_o = tgt_q;

  // R4
  enable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_EN) |=> ((dis_q & $past(wdata_i) & WR_MASK) == '0));

  // R5
  disable_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DSET) |=>
      ((dis_q & $past(wdata_i) & WR_MASK) == ($past(wdata_i) & WR_MASK)));

  // R6
  target_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_TGT) |=> (tgt_q == $past(wdata_i[TGT_W-1:0])));

  // R10
  fixed_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q & DIS_RST) == DIS_RST);

  // R11
  idle_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i != OFS_EN && addr_i != OFS_DSET && addr_i != OFS_TGT)
      |=> ($stable(dis_q) && $stable(tgt_q)));
endmodule

// File: rtl/sysirq_lvl_enc.sv
module sysirq_lvl_enc
  import sysirq_pkg::*;
#(
  parameter int unsigned SRC_W = NUM_SRC,
  parameter int unsigned LVL_W = NUM_LVL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] pend_i,
  input  logic [SRC_W-1:0] dis_i,
  input  logic             master_off_i,
  output logic [LVL_W-1:0] lvl_o
);
  logic [SRC_W-1:0] live;

  assign live = master_off_i ? '0 : (pend_i & ~dis_i);

  always_comb begin
    lvl_o = '0;
    for (int unsigned b = 0; b < SRC_W; b++) begin
      if (live[b] && lvl_of(b) != '0) lvl_o[lvl_of(b)] = 1'b1;
    end
  end

  // R8: levels 0, 1 and 14 have no source
  unused_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o[0] | lvl_o[1] | lvl_o[14]) == 1'b0);

  // R5
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~dis_i) == '0) |-> (lvl_o == '0));
endmodule

// File: rtl/sysirq_cpu_steer.sv
module sysirq_cpu_steer #(
  parameter int unsigned NUM_CPU = 16,
  parameter int unsigned LVL_W   = 16,
  localparam int unsigned TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [TGT_W-1:0]         tgt_i,
  input  logic [LVL_W-1:0]         lvl_i,
  output logic [NUM_CPU*LVL_W-1:0] cpu_lvl_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cpu_lvl_o[c*LVL_W +: LVL_W] = (tgt_i == TGT_W'(c)) ? lvl_i : '0;
  end
endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
  import sysirq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 16,
  localparam int unsigned TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned OUT_W  = NUM_CPU * NUM_LVL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [OUT_W-1:0]   cpu_lvl_o
);
  logic [NUM_SRC-1:0] pend;
  logic [DATA_W-1:0]  dis;
  logic [TGT_W-1:0]   tgt;
  logic [NUM_LVL-1:0] lvl;
  logic [NUM_CPU-1:0] cpu_busy;

  sysirq_src_latch #(.SRC_W(NUM_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pend_o (pend)
  );

  sysirq_ctl_regs #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend),
    .rdata_o (rdata_o),
    .dis_o   (dis),
    .tgt_o   (tgt)
  );

  sysirq_lvl_enc #(.SRC_W(NUM_SRC), .LVL_W(NUM_LVL)) u_enc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (pend),
    .dis_i        (dis),
    .master_off_i (dis[MASTER_BIT]),
    .lvl_o        (lvl)
  );

  sysirq_cpu_steer #(.NUM_CPU(NUM_CPU), .LVL_W(NUM_LVL)) u_steer (
    .tgt_i     (tgt),
    .lvl_i     (lvl),
    .cpu_lvl_o (cpu_lvl_o)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_busy
    assign cpu_busy[c] = |cpu_lvl_o[c*NUM_LVL +: NUM_LVL];
  end

  // R7
  master_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis[MASTER_BIT] |-> (cpu_lvl_o == '0));

  // R9
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cpu_busy));

  // R9
  target_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_busy != '0) |-> cpu_busy[tgt]);
endmodule

// File: tb/tb_sysirq_router.sv
module tb_sysirq_router;
  localparam int NCPU = 16;
  localparam int OW   = NCPU * 16;
  localparam logic [31:0] ROUTED_M = 32'h787F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   src = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [OW-1:0] lvl;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sysirq_router dut (
    .clk_i (clk), .rst_ni (rst_n), .src_i (src), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .cpu_lvl_o (lvl)
  );

  // {source pattern, level vector expected with all writable sources enabled}
  localparam logic [47:0] VECS [10] = '{
    {32'h0000_0080, 16'h0004},
    {32'h0000_C000, 16'h1000},
    {32'h0000_007F, 16'h0000},
    {32'h0001_0000, 16'h0040},
    {32'h000C_0000, 16'h0410},
    {32'h0050_0000, 16'h0900},
    {32'h1000_0000, 16'h8000},
    {32'h0002_2000, 16'h2000},
    {32'h0000_1F00, 16'h0AA8},
    {32'hFFFF_FFFF, 16'hBFFC}
  };

  task automatic chk(input string rq, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic drive(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
  endtask

  function automatic logic [OW-1:0] at_cpu(input logic [15:0] v, input int c);
    return OW'(v) << (16 * c);
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 pend", OW'(d), '0);
    rd(3'd1, d); chk("R1 dis", OW'(d), '0);
    rd(3'd4, d); chk("R1 tgt", OW'(d), '0);
    chk("R1 lvl", lvl, '0);

    // R3 undefined reads
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R3 undef read", OW'(d), '0);
    end

    // R6 target keeps low 4 bits
    wr(3'd4, 32'h0000_0015);
    rd(3'd4, d); chk("R6 tgt", OW'(d), OW'(32'h5));

    // R2 R8 R9 R10 table
    for (int i = 0; i < 10; i++) begin
      drive(VECS[i][47:16]);
      chk("R8 R9 R10 lvl", lvl, at_cpu(VECS[i][15:0], 5));
      rd(3'd0, d); chk("R2 pend", OW'(d), OW'(VECS[i][47:16] & ROUTED_M));
    end

    // R12 timing
    drive(32'h0);
    @(negedge clk);
    src = 32'h0008_0000;
    #1 chk("R12 before edge", lvl, '0);
    @(negedge clk);
    chk("R12 after edge", lvl, at_cpu(16'h0400, 5));

    // R9 retarget
    wr(3'd4, 32'h0000_000C);
    chk("R9 retarget", lvl, at_cpu(16'h0400, 12));

    // R7 master disable
    drive(32'h1008_0080);
    wr(3'd3, 32'h8000_0000);
    chk("R7 master off", lvl, '0);
    rd(3'd0, d); chk("R7 pend kept", OW'(d), OW'(32'h1008_0080));
    rd(3'd1, d); chk("R7 dis read", OW'(d), OW'(32'h8000_0000));
    wr(3'd2, 32'h8000_0000);
    chk("R7 master on", lvl, at_cpu(16'h8404, 12));

    // R5 disable one source, pending stays
    wr(3'd3, 32'h1000_0000);
    chk("R5 masked", lvl, at_cpu(16'h0404, 12));
    rd(3'd0, d); chk("R5 pend kept", OW'(d), OW'(32'h1008_0080));
    // R4 re-enable
    wr(3'd2, 32'h1000_0000);
    chk("R4 enabled", lvl, at_cpu(16'h8404, 12));

    // R10 attempt to enable fixed bits
    wr(3'd2, 32'hFFFF_FFFF);
    drive(32'h0822_007F);
    chk("R10 fixed off", lvl, '0);
    rd(3'd1, d); chk("R10 dis read", OW'(d), '0);

    // R11 writes to non-writable offsets
    wr(3'd3, 32'h0004_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R11 dis", OW'(d), OW'(32'h0004_0000));
    rd(3'd4, d); chk("R11 tgt", OW'(d), OW'(32'hC));
    wr(3'd2, 32'h0004_0000);

    // Same-edge: source rise with disable write
    drive(32'h0);
    @(negedge clk);
    src = 32'h4000_0000;
    req = 1'b1; we = 1'b1; addr = 3'd3; wdata = 32'h4000_0000;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R5 same edge masked", lvl, '0);
    rd(3'd0, d); chk("R2 same edge pend", OW'(d), OW'(32'h4000_0000));

    // Same-edge: enable write with another source rise
    @(negedge clk);
    src = 32'h4001_0000;
    req = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'h4000_0000;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R4 same edge both", lvl, at_cpu(16'h8040, 12));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule